// File: doc/BRIEF.md
# Pipelined Integer/Float Format Converter

This block converts single operands between signed two's-complement integers and binary floating-point values. Every operation carries its own direction bit and a 3-bit precision code, so a stream may alternate between integer-to-float and float-to-integer work, or between narrow and wide formats, on consecutive cycles. No drain or reconfiguration step is needed. Six float encodings are handled: two 8-bit variants (5 exponent/2 fraction bits and 4 exponent/3 fraction bits), IEEE half, the 16-bit "brain" format with an 8-bit exponent, IEEE single and IEEE double. The paired integer widths are 8, 16, 32 and 64 bits.

Operands enter on a valid/ready port. Ready is always high, because the unit takes one operation per cycle with no stalls. Results leave on a valid-only port after a fixed three-register pipeline. Stage one unpacks fields or takes the integer magnitude. Stage two either normalises by counting leading zeros or aligns the significand to the integer point. Stage three rounds and packs, or applies the sign and any saturation. Operand and result words sit in the low bits of a 64-bit bus.

Top module: `mpcvt`

## Requirements
- R1: `in_ready` is always 1. An operation sampled with `in_valid` high at a rising edge produces `out_valid` high after the second following edge, so it is seen at the third sampling edge. Idle cycles produce `out_valid` low at the same distance.
- R2: `in_op`=0 selects integer-to-float and `in_op`=1 selects float-to-integer. The precision code `in_prec` selects the format: 0 = 8-bit E5M2, 1 = 8-bit E4M3, 2 = half, 3 = 16-bit bfloat, 4 = single, 5 = double. The paired integer width is 8, 8, 16, 16, 32, 64 bits. Direction and precision may change on every cycle without affecting any result.
- R3: Integer-to-float reads the paired-width signed integer from the low bits of `in_data`. It produces the correctly rounded float (round to nearest, ties to even), with sign in bit E+M, biased exponent in bits E+M-1..M and fraction in bits M-1..0. Biases are 15, 7, 15, 127, 127 and 1023. Zero gives +0.
- R4: Float-to-integer truncates toward zero, and any value of magnitude below 1 gives 0.
- R5: Float-to-integer saturates infinities and out-of-range values to the most positive or most negative integer of the paired width and sets `out_overflow`. The most negative integer itself converts without overflow.
- R6: A float NaN gives result 0 with `out_invalid` set. For E4M3, only exponent 15 with fraction 7 is NaN, and there is no infinity. The other formats use an all-ones exponent with a nonzero fraction.
- R7: Precision codes 6 and 7 give result 0 with `out_invalid` set and `out_overflow` clear, in either direction.
- R8: Input bits above the selected width are ignored. Result bits above the result width (the integer width, or the float width) are 0.
- R9: While `rst_n` is low, `out_valid`, `out_invalid` and `out_overflow` are 0.
- R10: `out_invalid` and `out_overflow` are never set together. `out_overflow` is only set by float-to-integer operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Always 1: one operation accepted per cycle |
| in_op | input | 1 | 0 = integer to float, 1 = float to integer |
| in_prec | input | 3 | Precision code |
| in_data | input | 64 | Operand, packed in the low bits |
| out_valid | output | 1 | Result present |
| out_data | output | 64 | Result, packed in the low bits, upper bits zero |
| out_invalid | output | 1 | NaN operand or reserved precision code |
| out_overflow | output | 1 | Float-to-integer saturation occurred |

## Verification
The hardest cases to reach are float-to-integer boundaries: values whose exponent puts them just inside or just outside the integer range. Uniformly random bit patterns almost never land there, especially for the wide formats. The stimulus therefore often overwrites the exponent field with the bias plus a small offset spanning the integer width. Directed operands cover the most negative integer, E4M3's 448 and NaN code, and halfway ties in the rounder. All of these are interleaved with direction and precision changes on every cycle.

// File: rtl/mpcvt.sv
module mpcvt (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        in_op,
  input  logic [2:0]  in_prec,
  input  logic [63:0] in_data,
  output logic        out_valid,
  output logic [63:0] out_data,
  output logic        out_invalid,
  output logic        out_overflow
);

  function automatic logic [5:0] mw_f(input logic [2:0] p);
    case (p)
      3'd0: return 6'd2;
      3'd1: return 6'd3;
      3'd2: return 6'd10;
      3'd3: return 6'd7;
      3'd4: return 6'd23;
      default: return 6'd52;
    endcase
  endfunction

  function automatic logic [3:0] ew_f(input logic [2:0] p);
    case (p)
      3'd0: return 4'd5;
      3'd1: return 4'd4;
      3'd2: return 4'd5;
      3'd3, 3'd4: return 4'd8;
      default: return 4'd11;
    endcase
  endfunction

  function automatic logic [10:0] bias_f(input logic [2:0] p);
    case (p)
      3'd0, 3'd2: return 11'd15;
      3'd1: return 11'd7;
      3'd3, 3'd4: return 11'd127;
      default: return 11'd1023;
    endcase
  endfunction

  function automatic logic [6:0] iw_f(input logic [2:0] p);
    case (p)
      3'd0, 3'd1: return 7'd8;
      3'd2, 3'd3: return 7'd16;
      3'd4: return 7'd32;
      default: return 7'd64;
    endcase
  endfunction

  function automatic logic [63:0] wmask(input logic [6:0] w);
    return (w >= 7'd64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  assign in_ready = 1'b1;

  // stage 1: unpack / integer magnitude
  logic [6:0]  iw1;
  logic [5:0]  m1;
  logic [3:0]  x1;
  logic [10:0] b1, ef1, emx1;
  logic [63:0] fr1;
  logic signed [63:0] sx;
  assign iw1  = iw_f(in_prec);
  assign m1   = mw_f(in_prec);
  assign x1   = ew_f(in_prec);
  assign b1   = bias_f(in_prec);
  assign sx   = $signed(in_data << (7'd64 - iw1)) >>> (7'd64 - iw1);
  assign ef1  = 11'((in_data >> m1) & wmask({3'b0, x1}));
  assign emx1 = 11'(wmask({3'b0, x1}));
  assign fr1  = in_data & wmask({1'b0, m1});

  logic v1, op1, sg1, nan1, inf1, tiny1;
  logic [2:0] p1;
  logic [63:0] mag1;
  logic signed [12:0] e1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; op1 <= 1'b0; p1 <= '0; sg1 <= 1'b0; mag1 <= '0;
      e1 <= '0; nan1 <= 1'b0; inf1 <= 1'b0; tiny1 <= 1'b0;
    end else begin
      v1   <= in_valid;
      op1  <= in_op;
      p1   <= in_prec;
      sg1  <= in_op ? in_data[6'({2'b0, x1} + m1)] : sx[63];
      mag1 <= in_op ? (fr1 | (64'd1 << m1)) : (sx[63] ? $unsigned(-sx) : $unsigned(sx));
      e1   <= $signed({2'b0, ef1}) - $signed({2'b0, b1});
      nan1 <= in_op && ((in_prec == 3'd1) ? (ef1 == 11'd15 && fr1 == 64'd7)
                                          : (ef1 == emx1 && fr1 != 64'd0));
      inf1 <= in_op && in_prec != 3'd1 && ef1 == emx1 && fr1 == 64'd0;
      tiny1 <= ef1 < b1;
    end
  end

  // stage 2: leading-zero normalise / align to integer point
  logic [5:0]   lz;
  logic [6:0]   iw2;
  logic [5:0]   m2;
  logic [127:0] big, bsh;
  logic [63:0]  fmag, lim;
  always_comb begin
    lz = 6'd0;
    for (int i = 0; i < 64; i++)
      if (mag1[i]) lz = 6'(63 - i);
  end
  assign iw2  = iw_f(p1);
  assign m2   = mw_f(p1);
  assign big  = {64'b0, mag1} << e1[5:0];
  assign bsh  = big >> m2;
  assign fmag = bsh[63:0];
  assign lim  = (64'd1 << (iw2 - 7'd1)) - 64'd1 + {63'b0, sg1};

  logic v2, op2, sg2, zero2, nan2, ovf2;
  logic [2:0]  p2;
  logic [63:0] mag2;
  logic [5:0]  ex2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2 <= 1'b0; op2 <= 1'b0; p2 <= '0; sg2 <= 1'b0; mag2 <= '0;
      ex2 <= '0; zero2 <= 1'b0; nan2 <= 1'b0; ovf2 <= 1'b0;
    end else begin
      v2    <= v1;
      op2   <= op1;
      p2    <= p1;
      sg2   <= sg1;
      mag2  <= op1 ? fmag : (mag1 << lz);
      ex2   <= 6'd63 - lz;
      zero2 <= op1 ? tiny1 : (mag1 == 64'd0);
      nan2  <= op1 && nan1;
      ovf2  <= op1 && !nan1 &&
               (inf1 || (!tiny1 && (e1 >= $signed({6'b0, iw2}) || fmag > lim)));
    end
  end

  // stage 3: round and pack / sign and saturate
  logic [6:0]  iw3;
  logic [5:0]  m3;
  logic [3:0]  x3;
  logic [10:0] b3;
  logic [62:0] fsh;
  logic [52:0] frac, sum;
  logic [63:0] rr, fres, ires, half, res;
  logic [11:0] expo;
  logic        up, carry, bad;
  assign iw3   = iw_f(p2);
  assign m3    = mw_f(p2);
  assign x3    = ew_f(p2);
  assign b3    = bias_f(p2);
  assign fsh   = mag2[62:0] >> (6'd63 - m3);
  assign frac  = fsh[52:0];
  assign rr    = mag2 << (m3 + 6'd1);
  assign up    = rr[63] & ((|rr[62:0]) | frac[0]);
  assign sum   = frac + {52'b0, up};
  assign carry = sum[m3];
  assign expo  = {6'b0, ex2} + {11'b0, carry} + {1'b0, b3};
  assign fres  = ({63'b0, sg2} << ({2'b0, x3} + m3)) | ({52'b0, expo} << m3) |
                 ({11'b0, sum} & wmask({1'b0, m3}));
  assign half  = 64'd1 << (iw3 - 7'd1);
  assign ires  = ovf2 ? (sg2 ? half : half - 64'd1) : (sg2 ? (~mag2 + 64'd1) : mag2);
  assign bad   = p2 > 3'd5;
  assign res   = (bad || nan2 || zero2) ? 64'd0 : (op2 ? (ires & wmask(iw3)) : fres);

  logic op3;
  logic [2:0] p3;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_data <= '0; out_invalid <= 1'b0; out_overflow <= 1'b0;
      op3 <= 1'b0; p3 <= '0;
    end else begin
      out_valid    <= v2;
      out_data     <= res;
      out_invalid  <= v2 && (bad || nan2);
      out_overflow <= v2 && !bad && ovf2;
      op3          <= op2;
      p3           <= p2;
    end
  end

  a_r1_issue_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##2 out_valid);
  a_r1_idle_latency: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##2 !out_valid);
  a_r7_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_prec > 3'd5) |=> ##2 (out_invalid && !out_overflow && out_data == 64'd0));
  a_r6_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> out_data == 64'd0);
  a_r10_flags_apart: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_invalid && out_overflow));
  a_r10_ovf_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_overflow) |-> op3);
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data & ~wmask(op3 ? iw_f(p3)
                   : (7'(ew_f(p3)) + 7'(mw_f(p3)) + 7'd1))) == 64'd0);

endmodule

// File: tb/mpcvt_bench.sv
module mpcvt_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic in_op = 1'b0;
  logic [2:0] in_prec = '0;
  logic [63:0] in_data = '0;
  logic out_valid, out_invalid, out_overflow;
  logic [63:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mpcvt u_mpcvt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_prec(in_prec), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data),
    .out_invalid(out_invalid), .out_overflow(out_overflow)
  );

  function automatic void fmt(input bit [2:0] p, output int e, output int m,
                              output int b, output int iw);
    case (p)
      0: begin e = 5;  m = 2;  b = 15;   iw = 8;  end
      1: begin e = 4;  m = 3;  b = 7;    iw = 8;  end
      2: begin e = 5;  m = 10; b = 15;   iw = 16; end
      3: begin e = 8;  m = 7;  b = 127;  iw = 16; end
      4: begin e = 8;  m = 23; b = 127;  iw = 32; end
      default: begin e = 11; m = 52; b = 1023; iw = 64; end
    endcase
  endfunction

  function automatic bit [63:0] lowmask(input int w);
    return (w >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
  endfunction

  // Behavioural reference: integer arithmetic on whole values.
  function automatic void model(input bit op, input bit [2:0] p, input bit [63:0] d,
                                output bit [63:0] r, output bit inv, output bit ovf);
    int e, m, b, iw, hb, sh, ex;
    bit s;
    bit [63:0] mag, q, rem, hlf, ef, fr, lp;
    longint signed v;
    r = 0; inv = 0; ovf = 0;
    fmt(p, e, m, b, iw);
    if (p > 5) begin inv = 1; return; end
    if (!op) begin
      v = longint'(d << (64 - iw)) >>> (64 - iw);
      s = v < 0;
      mag = s ? 64'(-v) : 64'(v);
      if (mag == 0) return;
      hb = 0;
      for (int i = 0; i < 64; i++) if (mag[i]) hb = i;
      if (hb <= m) q = mag << (m - hb);
      else begin
        sh = hb - m;
        q = mag >> sh;
        rem = mag & ((64'd1 << sh) - 1);
        hlf = 64'd1 << (sh - 1);
        if (rem > hlf || (rem == hlf && q[0])) q = q + 1;
        if ((q >> (m + 1)) != 0) begin q = q >> 1; hb = hb + 1; end
      end
      r = (64'(s) << (e + m)) | (64'(hb + b) << m) | (q & lowmask(m));
    end else begin
      s = d[e + m];
      ef = (d >> m) & lowmask(e);
      fr = d & lowmask(m);
      lp = (64'd1 << (iw - 1)) - 1;
      if (p == 1 ? (ef == 15 && fr == 7) : (ef == lowmask(e) && fr != 0)) begin
        inv = 1; return;
      end
      if ((p != 1 && ef == lowmask(e)) || int'(ef) - b > 63) ovf = 1;
      else if (int'(ef) - b < 0) return;
      else begin
        ex = int'(ef) - b;
        q = (64'd1 << m) | fr;
        mag = (ex >= m) ? (q << (ex - m)) : (q >> (m - ex));
        if (s ? (mag > lp + 1) : (mag > lp)) ovf = 1;
        else begin r = (s ? (~mag + 1) : mag) & lowmask(iw); return; end
      end
      r = (s ? lp + 1 : lp) & lowmask(iw);
    end
  endfunction

  bit        pv[3];
  bit        pop[3];
  bit [2:0]  pp[3];
  bit [63:0] pd[3];
  bit        pi[3];
  bit        po[3];
  bit        psw[3];
  bit        last_op = 0;
  bit [2:0]  last_p = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) pv[k] = 0;
    end else begin
      for (int k = 2; k > 0; k--) begin
        pv[k] = pv[k-1]; pop[k] = pop[k-1]; pp[k] = pp[k-1];
        pd[k] = pd[k-1]; pi[k] = pi[k-1]; po[k] = po[k-1]; psw[k] = psw[k-1];
      end
      pv[0] = in_valid; pop[0] = in_op; pp[0] = in_prec;
      psw[0] = in_valid && (in_op != last_op || in_prec != last_p);
      if (in_valid) begin last_op = in_op; last_p = in_prec; end
      model(in_op, in_prec, in_data, pd[0], pi[0], po[0]);
    end
  end

  function automatic string tag_of(input int k);
    if (psw[k]) return "R2";
    if (pp[k] > 5) return "R7";
    if (!pop[k]) return "R3";
    if (pi[k]) return "R6";
    if (po[k]) return "R5";
    return "R4";
  endfunction

  always @(negedge clk) begin
    int e, m, b, iw;
    if (!done) begin
      if (!rst_n) begin
        checks++;
        if (out_valid || out_invalid || out_overflow) begin
          errors++;
          $display("FAIL R9 reset outputs: got %b%b%b expected 000", out_valid, out_invalid, out_overflow);
        end
      end else begin
        checks++;
        if (in_ready !== 1'b1) begin
          errors++;
          $display("FAIL R1 in_ready: got %b expected 1", in_ready);
        end
        checks++;
        if (out_valid !== pv[2]) begin
          errors++;
          $display("FAIL R1 out_valid: got %b expected %b", out_valid, pv[2]);
        end
        if (pv[2]) begin
          checks++;
          if (out_data !== pd[2] || out_invalid !== pi[2] || out_overflow !== po[2]) begin
            errors++;
            $display("FAIL %s op=%0d prec=%0d: got %h inv=%b ovf=%b expected %h inv=%b ovf=%b",
                     tag_of(2), pop[2], pp[2], out_data, out_invalid, out_overflow,
                     pd[2], pi[2], po[2]);
          end
          fmt(pp[2], e, m, b, iw);
          checks++;
          if (pp[2] <= 5 && (out_data & ~lowmask(pop[2] ? iw : e + m + 1)) != 0) begin
            errors++;
            $display("FAIL R8 upper bits: got %h expected 0 above bit %0d",
                     out_data, pop[2] ? iw : e + m + 1);
          end
          checks++;
          if ((out_invalid && out_overflow) || (out_overflow && !pop[2])) begin
            errors++;
            $display("FAIL R10 flags: got inv=%b ovf=%b op=%0d expected exclusive, overflow only for op 1",
                     out_invalid, out_overflow, pop[2]);
          end
        end
      end
    end
  end

  task automatic send(input bit op, input bit [2:0] p, input bit [63:0] d);
    @(negedge clk);
    in_valid = 1; in_op = op; in_prec = p; in_data = d;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; in_data = 64'hDEAD_BEEF_0BAD_F00D;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int e, m, b, iw;
    bit [63:0] d, ef;
    bit op;
    bit [2:0] p;
    void'($urandom(7));
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R3: integer to float, ties and extremes (upper garbage bits test R8)
    send(0, 0, 64'hABCD_0000_0000_00FF);
    send(0, 1, 64'h0000_0000_0000_007F);
    send(0, 1, 64'h0000_0000_0000_0080);
    send(0, 4, 64'h0000_0000_0100_0001);
    send(0, 4, 64'h0000_0000_0100_0003);
    send(0, 5, 64'h8000_0000_0000_0000);
    send(0, 3, 64'h1234_5678_0000_0000);
    idle();
    // R4/R5/R6: float to integer boundaries
    send(1, 4, 64'h0000_0000_C039_9999);
    send(1, 3, 64'h0000_0000_0000_C700);
    send(1, 3, 64'h0000_0000_0000_4700);
    send(1, 2, 64'h0000_0000_0000_7C00);
    send(1, 2, 64'h0000_0000_0000_FE00);
    send(1, 1, 64'h0000_0000_0000_007F);
    send(1, 1, 64'h0000_0000_0000_007E);
    send(1, 1, 64'h0000_0000_0000_00FE);
    send(1, 5, 64'hC3E0_0000_0000_0000);
    send(1, 5, 64'h43E0_0000_0000_0000);
    send(1, 0, 64'h0000_0000_0000_0037);
    // R7: reserved codes in both directions
    send(0, 6, 64'h55);
    send(1, 7, 64'h7F);
    idle();
    idle();
    // R2: direction and precision change every cycle, random data
    for (int n = 0; n < 3000; n++) begin
      op = 1'($urandom);
      p = 3'($urandom % 7);
      d = {$urandom, $urandom};
      fmt(p, e, m, b, iw);
      if (op && p <= 5 && ($urandom % 4) != 0) begin
        ef = 64'(b + int'($urandom % (iw + 3)) - 1);
        d = (d & ~(lowmask(e) << m)) | ((ef & lowmask(e)) << m);
      end
      if (($urandom % 8) == 0) idle();
      else send(op, p, d);
    end
    idle();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule